// File: doc/BRIEF.md
# Prioritized Processor Exception Entry Unit

This unit sits next to a simple 32-bit processor core and takes exceptions on its behalf. Eight exception sources feed a sticky pending register through single-cycle raise pulses. When the core strobes a check, the unit picks the most urgent pending cause and computes the exception entry state: a saved return address, a saved copy of the machine state word, a rewritten machine state word and the handler vector. It also clears the pending bit of the cause it took. A second, narrower check strobe looks only at the two asynchronous causes. The core uses this at points where synchronous faults have already been handled.

The control is a two-state machine. ST_IDLE is the rest state. ST_ENTRY is held for exactly one cycle per exception taken and drives `taken_o`. The transition GO_ENTRY (ST_IDLE or ST_ENTRY to ST_ENTRY) fires on any clock edge where a check strobe finds an eligible cause. The transition GO_IDLE (ST_ENTRY or ST_IDLE to ST_IDLE) fires on every other edge. Reset forces ST_IDLE. Back-to-back checks can therefore produce back-to-back entries.

Cause codes, which are also the bit positions in `raise_i`, run from most to least urgent: 0 instruction fetch fault, 1 program fault, 2 system call, 3 floating point disabled, 4 data access fault, 5 misalignment, 6 external interrupt, 7 timer (decrementer) event.

Top module: `exc_entry_unit`

## Requirements
- R1: On a full check (`chk_full_i`=1), the unit takes the eligible pending cause with the lowest code (0 is the most urgent, 7 the least). It takes at most one cause per check, and `cause_o` reports that code.
- R2: Causes 6 and 7 are eligible only when `msr_i` bit 15 is 1. When that bit is 0 they are not taken and stay pending.
- R3: On an external-only check (`chk_ext_i`=1, `chk_full_i`=0), only causes 6 and 7 are considered, with 6 ahead of 7. If neither is eligible, no entry occurs. When both strobes are high, the check is a full check.
- R4: `srr1_o` receives `msr_i` AND 0x87C0FFFF. Bit 30 is also set for cause 0, and 0x00020000 is also ORed in for cause 1.
- R5: `msr_o` is `msr_i` with bit 16 first copied into bit 0, and then the bits in 0x0004EF36 cleared.
- R6: `pc_o` is the handler vector: 0x400, 0x700, 0xC00, 0x800, 0x300, 0x600, 0x500 and 0x900 for causes 0 to 7 respectively.
- R7: `srr0_o` is `next_pc_i` for causes 6 and 7, and `cur_pc_i` for causes 0 to 5.
- R8: Only the pending bit of the cause taken is cleared. Every other pending cause stays pending and can be taken by a later check.
- R9: A pulse on `raise_i` bit k sets pending bit k, and that bit is visible to checks from the next cycle. A raise and a clear of the same bit in one cycle leave the bit set.
- R10: An entry completes in one clock. `taken_o` is high for exactly the cycle after each check that takes a cause, together with `cause_o`, `srr0_o`, `srr1_o`, `msr_o` and `pc_o`. The last four outputs hold their values between entries.
- R11: Synchronous reset clears all pending bits and sets `taken_o`, `cause_o`, `srr0_o`, `srr1_o`, `msr_o` and `pc_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raise_i | input | 8 | One raise pulse per cause, indexed by cause code |
| chk_full_i | input | 1 | Strobe: check all eight causes |
| chk_ext_i | input | 1 | Strobe: check the asynchronous causes only |
| cur_pc_i | input | 32 | Address of the current instruction |
| next_pc_i | input | 32 | Address of the next instruction |
| msr_i | input | 32 | Current machine state word |
| taken_o | output | 1 | One-cycle pulse: an exception was taken |
| cause_o | output | 3 | Code of the cause taken |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved machine state copy |
| msr_o | output | 32 | Rewritten machine state word |
| pc_o | output | 32 | Handler vector for both current and next PC |

## Verification
The assertions that look back one cycle assume that `msr_i` and the check strobes seen at the edge belong to the check that produced the entry. In other words, inputs are steady across each rising edge. The bench ensures this by changing every input only on falling edges. It also draws `raise_i` as a sparse random mask, so that multi-cause priority and later retakes of bits left pending both occur often. The bench makes no assumption about when strobes may overlap. Both strobes, and raises that coincide with clears, are drawn freely.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NUM_CAUSE = 8;
    localparam int CODE_W    = $clog2(NUM_CAUSE);
    localparam int XLEN      = 32;

    typedef enum logic [CODE_W-1:0] {
        CAUSE_IFETCH = 3'd0,
        CAUSE_PROG   = 3'd1,
        CAUSE_SCALL  = 3'd2,
        CAUSE_FPOFF  = 3'd3,
        CAUSE_DACC   = 3'd4,
        CAUSE_ALIGN  = 3'd5,
        CAUSE_EXTIRQ = 3'd6,
        CAUSE_TIMER  = 3'd7
    } exc_cause_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ENTRY = 1'b1
    } entry_state_e;

    localparam logic [XLEN-1:0]      SAVE_MASK   = 32'h87C0_FFFF;
    localparam logic [XLEN-1:0]      CLEAR_MASK  = 32'h0004_EF36;
    localparam logic [XLEN-1:0]      FETCH_TAG   = 32'h4000_0000;
    localparam logic [XLEN-1:0]      PROG_TAG    = 32'h0002_0000;
    localparam int                   EE_BIT      = 15;
    localparam int                   ILE_BIT     = 16;
    localparam logic [NUM_CAUSE-1:0] ASYNC_SET   = 8'hC0;
endpackage

// File: rtl/exc_pending.sv
module exc_pending
    import exc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CAUSE-1:0] raise_i,
    input  logic [NUM_CAUSE-1:0] clear_i,
    output logic [NUM_CAUSE-1:0] pend_o
);
    logic [NUM_CAUSE-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clear_i) | raise_i;
    end

    assign pend_o = pend_q;

    // R9
    raise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|raise_i) |=> ((pend_q & $past(raise_i)) == $past(raise_i)));
endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
(
    input  logic [NUM_CAUSE-1:0] pend_i,
    input  logic                 ee_i,
    input  logic                 full_i,
    input  logic                 ext_i,
    output logic                 valid_o,
    output logic [CODE_W-1:0]    code_o,
    output logic [NUM_CAUSE-1:0] grant_o
);
    logic [NUM_CAUSE-1:0] elig;

    always_comb begin
        elig = '0;
        if (full_i)     elig = pend_i & (ee_i ? '1 : ~ASYNC_SET);
        else if (ext_i) elig = pend_i & (ee_i ? ASYNC_SET : '0);
    end

    always_comb begin
        valid_o = 1'b0;
        code_o  = '0;
        grant_o = '0;
        for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
            if (elig[i]) begin
                valid_o = 1'b1;
                code_o  = i[CODE_W-1:0];
                grant_o = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    // R1
    always_comb onehot_grant_chk: assert ($onehot0(grant_o));
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
    import exc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   msr_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic [XLEN-1:0]   next_pc_i,
    output logic [XLEN-1:0]   srr0_o,
    output logic [XLEN-1:0]   srr1_o,
    output logic [XLEN-1:0]   msr_o,
    output logic [XLEN-1:0]   vec_o
);
    exc_cause_e cause;
    logic [XLEN-1:0] le_copied;

    assign cause = exc_cause_e'(code_i);

    always_comb begin
        le_copied    = msr_i;
        le_copied[0] = msr_i[ILE_BIT];
        msr_o        = le_copied & ~CLEAR_MASK;
    end

    always_comb begin
        srr0_o = cur_pc_i;
        srr1_o = msr_i & SAVE_MASK;
        vec_o  = '0;
        unique case (cause)
            CAUSE_IFETCH: begin vec_o = 32'h400; srr1_o = (msr_i & SAVE_MASK) | FETCH_TAG; end
            CAUSE_PROG:   begin vec_o = 32'h700; srr1_o = (msr_i & SAVE_MASK) | PROG_TAG;  end
            CAUSE_SCALL:  vec_o = 32'hC00;
            CAUSE_FPOFF:  vec_o = 32'h800;
            CAUSE_DACC:   vec_o = 32'h300;
            CAUSE_ALIGN:  vec_o = 32'h600;
            CAUSE_EXTIRQ: begin vec_o = 32'h500; srr0_o = next_pc_i; end
            CAUSE_TIMER:  begin vec_o = 32'h900; srr0_o = next_pc_i; end
        endcase
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  raise_i,
    input  logic        chk_full_i,
    input  logic        chk_ext_i,
    input  logic [31:0] cur_pc_i,
    input  logic [31:0] next_pc_i,
    input  logic [31:0] msr_i,
    output logic        taken_o,
    output logic [2:0]  cause_o,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o,
    output logic [31:0] pc_o
);
    entry_state_e state_q, state_d;

    logic [NUM_CAUSE-1:0] pend, grant, clear;
    logic                 hit;
    logic [CODE_W-1:0]    code;
    logic [XLEN-1:0]      srr0_c, srr1_c, msr_c, vec_c;

    exc_pending u_pend (
        .clk     (clk),
        .rst     (rst),
        .raise_i (raise_i),
        .clear_i (clear),
        .pend_o  (pend)
    );

    exc_select u_sel (
        .pend_i  (pend),
        .ee_i    (msr_i[EE_BIT]),
        .full_i  (chk_full_i),
        .ext_i   (chk_ext_i),
        .valid_o (hit),
        .code_o  (code),
        .grant_o (grant)
    );

    exc_state_calc u_calc (
        .code_i    (code),
        .msr_i     (msr_i),
        .cur_pc_i  (cur_pc_i),
        .next_pc_i (next_pc_i),
        .srr0_o    (srr0_c),
        .srr1_o    (srr1_c),
        .msr_o     (msr_c),
        .vec_o     (vec_c)
    );

    assign clear = hit ? grant : '0;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = hit ? ST_ENTRY : ST_IDLE;
            ST_ENTRY: state_d = hit ? ST_ENTRY : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_o <= '0;
            srr0_o  <= '0;
            srr1_o  <= '0;
            msr_o   <= '0;
            pc_o    <= '0;
        end else if (state_d == ST_ENTRY) begin
            cause_o <= code;
            srr0_o  <= srr0_c;
            srr1_o  <= srr1_c;
            msr_o   <= msr_c;
            pc_o    <= vec_c;
        end
    end

    assign taken_o = (state_q == ST_ENTRY);

    // R2
    async_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (taken_o && cause_o[2:1] == 2'b11) |-> $past(msr_i[EE_BIT]));

    // R3
    ext_only_chk: assert property (@(posedge clk) disable iff (rst)
        (taken_o && $past(chk_ext_i && !chk_full_i)) |-> (cause_o[2:1] == 2'b11));

    // R5
    msr_rewrite_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (msr_o[0] == $past(msr_i[ILE_BIT]) && !msr_o[EE_BIT]));

    // R6
    vector_shape_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (pc_o[31:12] == '0 && pc_o[7:0] == '0 && pc_o[11:8] != '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!taken_o && $past(!taken_o)) |-> ($stable(pc_o) && $stable(srr0_o)));
endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  raise = '0;
    logic        chk_full = 1'b0, chk_ext = 1'b0;
    logic [31:0] cur_pc = '0, next_pc = '0, msr = '0;
    logic        taken;
    logic [2:0]  cause;
    logic [31:0] srr0, srr1, msr_n, pc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0]  mp = '0;
    logic        e_taken = 1'b0;
    logic [2:0]  e_cause = '0;
    logic [31:0] e_srr0 = '0, e_srr1 = '0, e_msr = '0, e_pc = '0;
    string       e_tag = "R1";

    always #10 clk = ~clk;

    exc_entry_unit u_exc_entry_unit (
        .clk(clk), .rst(rst), .raise_i(raise), .chk_full_i(chk_full),
        .chk_ext_i(chk_ext), .cur_pc_i(cur_pc), .next_pc_i(next_pc),
        .msr_i(msr), .taken_o(taken), .cause_o(cause), .srr0_o(srr0),
        .srr1_o(srr1), .msr_o(msr_n), .pc_o(pc)
    );

    function automatic int pick(logic [7:0] p, logic f, logic x, logic [31:0] m);
        logic [7:0] el;
        el = f ? (p & (m[15] ? 8'hFF : 8'h3F)) : x ? (p & (m[15] ? 8'hC0 : 8'h00)) : 8'h00;
        for (int i = 0; i < 8; i++) if (el[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] vec_of(int k);
        case (k)
            0: return 32'h400; 1: return 32'h700; 2: return 32'hC00; 3: return 32'h800;
            4: return 32'h300; 5: return 32'h600; 6: return 32'h500; default: return 32'h900;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare outputs against the model, then apply new inputs and advance the model
    task automatic step(logic [7:0] r, logic f, logic x, logic [31:0] m);
        int k;
        @(negedge clk);
        chk({e_tag, "/R10 taken"}, {31'd0, taken}, {31'd0, e_taken});
        if (e_taken) chk({e_tag, " cause"}, {29'd0, cause}, {29'd0, e_cause});
        chk("R7 srr0", srr0, e_srr0);
        chk("R4 srr1", srr1, e_srr1);
        chk("R5 msr", msr_n, e_msr);
        chk("R6 pc", pc, e_pc);
        raise = r; chk_full = f; chk_ext = x; msr = m;
        cur_pc = $urandom; next_pc = cur_pc + 32'd4;
        k = pick(mp, f, x, m);
        e_tag = f ? "R1/R2/R8" : "R3/R8";
        if (k >= 0) begin
            e_taken = 1'b1;
            e_cause = k[2:0];
            e_srr0 = (k >= 6) ? next_pc : cur_pc;
            e_srr1 = (m & 32'h87C0FFFF) | (k == 0 ? 32'h40000000 : 32'h0)
                     | (k == 1 ? 32'h00020000 : 32'h0);
            e_msr = {m[31:1], m[16]} & ~32'h0004EF36;
            e_pc = vec_of(k);
            mp[k] = 1'b0;
        end else begin
            e_taken = 1'b0;
        end
        mp = mp | r;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 taken", {31'd0, taken}, 32'd0);
        chk("R11 cause", {29'd0, cause}, 32'd0);
        chk("R11 srr0", srr0, 0); chk("R11 srr1", srr1, 0);
        chk("R11 msr", msr_n, 0); chk("R11 pc", pc, 0);
        rst = 1'b0;
        // R11: reset left nothing pending
        step(8'h00, 1'b1, 1'b0, 32'h0000_8000);
        // R1/R8: all causes pending, full checks take 0..7 in order
        step(8'hFF, 1'b0, 1'b0, 32'h0);
        for (int i = 0; i < 8; i++) step(8'h00, 1'b1, 1'b0, 32'hFFFF_FFFF);
        step(8'h00, 1'b1, 1'b0, 32'hFFFF_FFFF);
        // R2: async causes gated by bit 15, stay pending
        step(8'hC1, 1'b0, 1'b0, 32'h0);
        step(8'h00, 1'b1, 1'b0, 32'h0001_0000);
        step(8'h00, 1'b1, 1'b0, 32'h0001_0000);
        // R3: external-only check with bit 15 clear takes nothing, then 6 before 7
        step(8'h01, 1'b0, 1'b1, 32'h0);
        step(8'h00, 1'b0, 1'b1, 32'h0000_8000);
        step(8'h00, 1'b0, 1'b1, 32'h0000_8000);
        step(8'h00, 1'b0, 1'b1, 32'h0000_8000);
        // R3: both strobes means full check, takes cause 0
        step(8'h00, 1'b1, 1'b1, 32'h0000_8000);
        // R9: raise and clear of the same bit in one cycle keeps it set
        step(8'h04, 1'b0, 1'b0, 32'h0);
        step(8'h04, 1'b1, 1'b0, 32'h0);
        step(8'h00, 1'b1, 1'b0, 32'h0);
        step(8'h00, 1'b1, 1'b0, 32'h0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] r;
            logic [31:0] m;
            r = 8'($urandom) & 8'($urandom) & 8'($urandom);
            m = $urandom;
            if ($urandom % 4 != 0) m[15] = 1'b1;
            step(r, ($urandom % 3) == 0, ($urandom % 4) == 0, m);
        end
        step(8'h00, 1'b0, 1'b0, 32'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule